// File: doc/BRIEF.md
# Time-Windowed Stream Policer

This block sits in the ingress path of a switch port, after header parsing, and performs per-stream admission control. A parsed frame arrives with its destination MAC address, VLAN ID and priority code point. The block looks that triple up in a small fully associative table of stream entries. A frame that hits an entry has its destinations replaced by the entry's actions: forward to a set of ports, trap to the CPU port, or discard. An entry may also be marked time-critical. It is then tied to an external gate signal, and a frame arriving while that gate is closed is discarded. Each entry also carries a length limit.

A frame that hits no entry leaves with the forwarding mask it came in with, and the policer takes no part in its handling. Every frame the policer discards is charged to a saturating drop counter of the entry it hit. The cause may be a closed gate, an over-long frame or an empty destination set. Software reads the counters through an index/data port, and a read does not clear them.

Entries are loaded through a one-entry-per-cycle configuration port. The design is sized by parameters: a default of 16 entries, and a structure that grows toward on the order of a thousand streams.

Top module: `tw_stream_policer`

## Requirements
- R1: After reset every entry is invalid, every drop counter reads 0, and out_valid, out_mask, out_drop and out_hit are 0.
- R2: An entry matches only when all 63 key bits are equal: 48-bit MAC, 12-bit VID and 3-bit PCP. When several valid entries match, the one with the lowest index is used.
- R3: A frame that matches no valid entry leaves with out_mask equal to its in_fwd, out_drop 0 and out_hit 0, and no counter changes.
- R4: For a hit, the destination mask is the entry's redirect mask with bit CPU_PORT additionally set when the trap action is set. When the entry's drop action is set, the mask is empty.
- R5: A frame hitting a time-critical entry whose bit in gate_open (bit i for entry i) is 0 is dropped. A non-time-critical entry ignores gate_open.
- R6: A hit frame whose in_len exceeds the entry's maximum length is dropped. A length equal to the maximum is accepted.
- R7: A hit frame whose destination mask is empty is dropped. A dropped frame always leaves with out_mask 0 and out_drop 1.
- R8: Each dropped hit frame adds exactly 1 to the counter of the entry it hit. A counter at 2^CNT_W-1 stays there.
- R9: rd_data shows the counter selected by rd_idx one cycle later, and reading never changes it. If that counter is incremented in the same cycle, rd_data shows the value before the increment.
- R10: A configuration write that makes an entry valid and time-critical, with no trap and an empty redirect mask, is ignored and leaves the previous entry contents in force. A write with cfg_valid 0 invalidates the entry.
- R11: Each frame presented with in_valid appears on the outputs, with out_valid 1, exactly one clock later. Cycles without in_valid give out_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one stream entry |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Entry enable (0 invalidates) |
| cfg_da | input | 48 | Entry destination MAC key |
| cfg_vid | input | 12 | Entry VLAN ID key |
| cfg_pcp | input | 3 | Entry priority key |
| cfg_trap | input | 1 | Trap-to-CPU action |
| cfg_drop | input | 1 | Discard action |
| cfg_redir | input | PORTS | Redirect port mask |
| cfg_tc | input | 1 | Time-critical (gated) entry |
| cfg_maxlen | input | LEN_W | Maximum accepted frame length |
| in_valid | input | 1 | Parsed frame present |
| in_da | input | 48 | Frame destination MAC |
| in_vid | input | 12 | Frame VLAN ID |
| in_pcp | input | 3 | Frame priority code point |
| in_len | input | LEN_W | Frame length |
| in_fwd | input | PORTS | Forwarding mask from the normal lookup |
| gate_open | input | N_ENT | Current gate state, one bit per entry |
| out_valid | output | 1 | Result valid |
| out_mask | output | PORTS | Final destination mask |
| out_drop | output | 1 | Frame discarded by the policer |
| out_hit | output | 1 | Frame matched a stream entry |
| rd_idx | input | IDX_W | Counter index to read |
| rd_data | output | CNT_W | Drop counter value |

## Verification
The delicate coincidence is a drop counter being charged for a frame in the same cycle that software reads that same counter. The bench provokes it by presenting a frame that must be dropped on entry 2 on the very clock edge that rd_idx selects entry 2. It judges the outcome by requiring the old count on rd_data one cycle later and the incremented count on a following read. Sweeps over all gate patterns, boundary lengths and all 63 single-bit key flips are compared against an arithmetic model kept in the bench. That model also covers counter saturation and priority between duplicate keys.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  typedef struct packed {
    logic [47:0] da;
    logic [11:0] vid;
    logic [2:0]  pcp;
  } skey_t;
endpackage

// File: rtl/tsp_match.sv
module tsp_match
  import tsp_pkg::*;
#(
  parameter int N_ENT = 16,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  skey_t                   key,
  input  skey_t [N_ENT-1:0]       ent_key,
  input  logic  [N_ENT-1:0]       ent_vld,
  output logic                    hit,
  output logic  [IDX_W-1:0]       idx
);
  logic [N_ENT-1:0] eq;

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
      assign eq[g] = ent_vld[g] && (ent_key[g] == key);
    end
  endgenerate

  // lowest index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  p_hit_eq_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> eq[idx]);
  p_miss_none_r2: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (eq == '0));
endmodule

// File: rtl/tsp_decide.sv
module tsp_decide #(
  parameter int PORTS    = 8,
  parameter int LEN_W    = 14,
  parameter int CPU_PORT = 0
) (
  input  logic             trap,
  input  logic             drop,
  input  logic [PORTS-1:0] redir,
  input  logic             tc,
  input  logic             gate,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] maxlen,
  output logic [PORTS-1:0] dmask,
  output logic             viol
);
  always_comb begin
    dmask = drop ? '0 : redir;
    if (!drop) dmask[CPU_PORT] = dmask[CPU_PORT] | trap;
    viol = (tc && !gate) || (len > maxlen) || (dmask == '0);
  end
endmodule

// File: rtl/tsp_counters.sv
module tsp_counters #(
  parameter int N_ENT = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] cnt [N_ENT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) cnt[i] <= '0;
      rd_data <= '0;
    end else begin
      if (inc && (cnt[inc_idx] != {CNT_W{1'b1}}))
        cnt[inc_idx] <= cnt[inc_idx] + CNT_W'(1);
      rd_data <= cnt[rd_idx];
    end
  end

  generate
    for (genvar g = 0; g < N_ENT; g++) begin : g_chk
      p_cnt_mono_r8: assert property (@(posedge clk) disable iff (rst)
        cnt[g] >= $past(cnt[g]));
      p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt[g] == {CNT_W{1'b1}}) |=> (cnt[g] == {CNT_W{1'b1}}));
    end
  endgenerate
endmodule

// File: rtl/tw_stream_policer.sv
module tw_stream_policer
  import tsp_pkg::*;
#(
  parameter int N_ENT    = 16,
  parameter int PORTS    = 8,
  parameter int LEN_W    = 14,
  parameter int CNT_W    = 32,
  parameter int CPU_PORT = 0,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [47:0]      cfg_da,
  input  logic [11:0]      cfg_vid,
  input  logic [2:0]       cfg_pcp,
  input  logic             cfg_trap,
  input  logic             cfg_drop,
  input  logic [PORTS-1:0] cfg_redir,
  input  logic             cfg_tc,
  input  logic [LEN_W-1:0] cfg_maxlen,
  input  logic             in_valid,
  input  logic [47:0]      in_da,
  input  logic [11:0]      in_vid,
  input  logic [2:0]       in_pcp,
  input  logic [LEN_W-1:0] in_len,
  input  logic [PORTS-1:0] in_fwd,
  input  logic [N_ENT-1:0] gate_open,
  output logic             out_valid,
  output logic [PORTS-1:0] out_mask,
  output logic             out_drop,
  output logic             out_hit,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_data
);
  skey_t [N_ENT-1:0]             e_key;
  logic  [N_ENT-1:0]             e_vld, e_trap, e_drop, e_tc;
  logic  [N_ENT-1:0][PORTS-1:0]  e_redir;
  logic  [N_ENT-1:0][LEN_W-1:0]  e_max;

  // a gated entry needs somewhere to send its frames
  logic cfg_bad;
  assign cfg_bad = cfg_valid && cfg_tc && !cfg_trap && (cfg_redir == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld <= '0;
    end else if (cfg_we && !cfg_bad) begin
      e_vld[cfg_idx] <= cfg_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && !cfg_bad && cfg_valid) begin
      e_key[cfg_idx]   <= '{da: cfg_da, vid: cfg_vid, pcp: cfg_pcp};
      e_trap[cfg_idx]  <= cfg_trap;
      e_drop[cfg_idx]  <= cfg_drop;
      e_tc[cfg_idx]    <= cfg_tc;
      e_redir[cfg_idx] <= cfg_redir;
      e_max[cfg_idx]   <= cfg_maxlen;
    end
  end

  skey_t            fkey;
  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  logic [PORTS-1:0] d_mask;
  logic             d_viol;

  assign fkey = '{da: in_da, vid: in_vid, pcp: in_pcp};

  tsp_match #(.N_ENT(N_ENT)) u_match (
    .clk(clk), .rst(rst), .key(fkey), .ent_key(e_key), .ent_vld(e_vld),
    .hit(m_hit), .idx(m_idx)
  );

  tsp_decide #(.PORTS(PORTS), .LEN_W(LEN_W), .CPU_PORT(CPU_PORT)) u_decide (
    .trap(e_trap[m_idx]), .drop(e_drop[m_idx]), .redir(e_redir[m_idx]),
    .tc(e_tc[m_idx]), .gate(gate_open[m_idx]), .len(in_len),
    .maxlen(e_max[m_idx]), .dmask(d_mask), .viol(d_viol)
  );

  tsp_counters #(.N_ENT(N_ENT), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(in_valid && m_hit && d_viol), .inc_idx(m_idx),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_drop  <= 1'b0;
      out_hit   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && m_hit;
      if (!in_valid) begin
        out_mask <= '0;
        out_drop <= 1'b0;
      end else if (m_hit) begin
        out_mask <= d_viol ? '0 : d_mask;
        out_drop <= d_viol;
      end else begin
        out_mask <= in_fwd;
        out_drop <= 1'b0;
      end
    end
  end

  p_latency_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_miss_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !m_hit) |=> (out_mask == $past(in_fwd)) && !out_drop && !out_hit);
  p_gate_closed_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && m_hit && e_tc[m_idx] && !gate_open[m_idx]) |=> out_drop);
  p_drop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_drop) |-> (out_mask == '0) && out_hit);
  p_reject_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_bad) |=> (e_vld == $past(e_vld)));
endmodule

// File: tb/sim_tw_stream_policer.sv
`timescale 1ns/1ps
module sim_tw_stream_policer;
  localparam int NE = 4;
  localparam int NP = 4;
  localparam int LW = 11;
  localparam int CW = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          cfg_we = 0, cfg_valid = 0, cfg_trap = 0, cfg_drop = 0, cfg_tc = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [47:0]   cfg_da = '0;
  logic [11:0]   cfg_vid = '0;
  logic [2:0]    cfg_pcp = '0;
  logic [NP-1:0] cfg_redir = '0;
  logic [LW-1:0] cfg_maxlen = '0;
  logic          in_valid = 0;
  logic [47:0]   in_da = '0;
  logic [11:0]   in_vid = '0;
  logic [2:0]    in_pcp = '0;
  logic [LW-1:0] in_len = '0;
  logic [NP-1:0] in_fwd = '0;
  logic [NE-1:0] gate_open = '0;
  logic          out_valid, out_drop, out_hit;
  logic [NP-1:0] out_mask;
  logic [IW-1:0] rd_idx = '0;
  logic [CW-1:0] rd_data;

  tw_stream_policer #(.N_ENT(NE), .PORTS(NP), .LEN_W(LW), .CNT_W(CW), .CPU_PORT(0)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_da(cfg_da), .cfg_vid(cfg_vid), .cfg_pcp(cfg_pcp), .cfg_trap(cfg_trap),
    .cfg_drop(cfg_drop), .cfg_redir(cfg_redir), .cfg_tc(cfg_tc), .cfg_maxlen(cfg_maxlen),
    .in_valid(in_valid), .in_da(in_da), .in_vid(in_vid), .in_pcp(in_pcp),
    .in_len(in_len), .in_fwd(in_fwd), .gate_open(gate_open),
    .out_valid(out_valid), .out_mask(out_mask), .out_drop(out_drop), .out_hit(out_hit),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the table
  bit            mv [NE];
  logic [62:0]   mk [NE];
  bit            mt [NE], md [NE], mc [NE];
  logic [NP-1:0] mr [NE];
  logic [LW-1:0] mm [NE];
  int            ec [NE];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input bit v, input logic [62:0] k, input bit tr,
                     input bit dr, input logic [NP-1:0] rd, input bit tc, input int mx);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_valid = v;
    {cfg_da, cfg_vid, cfg_pcp} = k;
    cfg_trap = tr; cfg_drop = dr; cfg_redir = rd; cfg_tc = tc; cfg_maxlen = LW'(mx);
    @(negedge clk);
    cfg_we = 0;
    if (!(v && tc && !tr && rd == '0)) begin
      mv[idx] = v;
      if (v) begin
        mk[idx] = k; mt[idx] = tr; md[idx] = dr; mr[idx] = rd; mc[idx] = tc; mm[idx] = LW'(mx);
      end
    end
  endtask

  // expected outcome, returns hit index or -1
  function automatic int model(input logic [62:0] k, input int len, input logic [NE-1:0] g,
                               input logic [NP-1:0] fwd, output logic [NP-1:0] em,
                               output bit edrop);
    int h = -1;
    logic [NP-1:0] tm;
    for (int i = NE - 1; i >= 0; i--) if (mv[i] && mk[i] == k) h = i;
    if (h < 0) begin
      em = fwd; edrop = 0;
    end else begin
      tm = md[h] ? '0 : (mr[h] | (mt[h] ? NP'(1) : NP'(0)));
      edrop = (mc[h] && !g[h]) || (len > int'(mm[h])) || (tm == '0);
      em = edrop ? '0 : tm;
    end
    return h;
  endfunction

  task automatic frame(input logic [62:0] k, input int len, input logic [NE-1:0] g,
                       input logic [NP-1:0] fwd, input string req);
    logic [NP-1:0] em;
    bit ed;
    int h;
    h = model(k, len, g, fwd, em, ed);
    @(negedge clk);
    in_valid = 1; {in_da, in_vid, in_pcp} = k; in_len = LW'(len);
    gate_open = g; in_fwd = fwd;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1'b1, "R11 valid", out_valid, 1);
    chk(out_hit == (h >= 0), {req, " hit"}, out_hit, h >= 0);
    chk(out_mask == em, {req, " mask"}, out_mask, em);
    chk(out_drop == ed, {req, " drop"}, out_drop, ed);
    if (h >= 0 && ed && ec[h] < (1 << CW) - 1) ec[h]++;
  endtask

  task automatic rdchk(input int idx, input string req);
    @(negedge clk);
    rd_idx = IW'(idx);
    @(negedge clk);
    chk(rd_data == CW'(ec[idx]), req, rd_data, ec[idx]);
  endtask

  localparam logic [62:0] K0 = {48'h0A1B_2C3D_4E5F, 12'h064, 3'd5};
  localparam logic [62:0] K1 = {48'h0102_0304_0506, 12'h001, 3'd0};
  localparam logic [62:0] K2 = {48'hFFEE_DDCC_BBAA, 12'hFFF, 3'd7};
  localparam logic [62:0] K3 = {48'h1234_5678_9ABC, 12'h222, 3'd3};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [62:0] kf;
    int old;
    for (int i = 0; i < NE; i++) begin mv[i] = 0; ec[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(out_valid == 0 && out_mask == 0 && out_drop == 0 && out_hit == 0,
        "R1 outputs", {out_valid, out_mask, out_drop, out_hit}, 0);
    for (int i = 0; i < NE; i++) rdchk(i, "R1 counter");
    frame(K0, 64, '1, 4'b1010, "R1 empty table");

    cfg(0, 1, K0, 0, 0, 4'b0110, 0, 100);
    cfg(1, 1, K1, 1, 0, 4'b0000, 1, 200);
    cfg(2, 1, K2, 0, 1, 4'b1000, 0, 1500);
    cfg(3, 1, K0, 0, 0, 4'b0001, 0, 2000);

    // R11 idle cycle
    @(negedge clk);
    chk(out_valid == 0, "R11 idle", out_valid, 0);

    // R2 priority, R4 mask, R5 gate sweep, R6 length boundaries
    for (int g = 0; g < 16; g++) begin
      foreach (ec[j]) ;
      frame(K0, 100, NE'(g), 4'b1111, "R2 R4 R5");
      frame(K0, 101, NE'(g), 4'b1111, "R6 over");
      frame(K1, 200, NE'(g), 4'b0100, "R5 R4 trap");
      frame(K1, 201, NE'(g), 4'b0100, "R6 R5");
      frame(K1, 0, NE'(g), 4'b0100, "R5");
      frame(K3, 300, NE'(g), NP'(g), "R3 miss");
    end
    rdchk(0, "R8 count e0");
    rdchk(1, "R8 count e1");
    rdchk(3, "R8 count e3");

    // R2 every single-bit key difference misses
    for (int b = 0; b < 63; b++) begin
      kf = K0 ^ (63'd1 << b);
      frame(kf, 50, '1, 4'b1001, "R2 bit flip");
    end

    // R9 same-cycle read and increment on entry 2 (drop action, R4 R7)
    frame(K2, 60, '1, 4'b1111, "R7 drop action");
    rdchk(2, "R9 read");
    old = ec[2];
    @(negedge clk);
    in_valid = 1; {in_da, in_vid, in_pcp} = K2; in_len = LW'(60);
    gate_open = '1; in_fwd = 4'b1111; rd_idx = 2'd2;
    @(negedge clk);
    in_valid = 0;
    chk(rd_data == CW'(old), "R9 same cycle old value", rd_data, old);
    chk(out_drop == 1 && out_mask == 0, "R7 same cycle drop", {out_drop, out_mask}, 5'h10);
    ec[2]++;
    rdchk(2, "R9 after increment");
    rdchk(2, "R9 read does not clear");

    // R8 saturation
    for (int n = 0; n < 20; n++) frame(K2, 60, '0, 4'b0000, "R7 R8");
    rdchk(2, "R8 saturated");
    chk(ec[2] == (1 << CW) - 1, "R8 model sat", ec[2], (1 << CW) - 1);

    // R10 rejected gated entry without destination
    cfg(3, 1, K3, 0, 0, 4'b0000, 1, 500);
    frame(K3, 10, '1, 4'b0011, "R10 reject miss");
    cfg(0, 0, K0, 0, 0, 4'b0000, 0, 0);
    frame(K0, 100, '0, 4'b1111, "R10 old entry kept");
    frame(K0, 2000, '0, 4'b1111, "R6 equal max");
    frame(K0, 2001, '0, 4'b1111, "R6 over max");
    rdchk(3, "R8 e3");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule